// File: doc/BRIEF.md
# Paged LFSR Instruction Fetch Unit

This unit produces the program addresses for a small 4-bit controller and hands each complete instruction to the execution stage. The 12-bit program counter is split into a 6-bit page number and a 6-bit step. The step does not count in binary: it moves along a 6-bit linear feedback shift register sequence. Straight-line code inside a page therefore sits at scattered step values and never leaves the page unless a jump or a return reloads the counter.

Each byte comes from a synchronous program ROM with one cycle of read latency. The unit sees the opcode and recognises two-byte instructions. For those it reads the following byte as the operand before it reports the instruction. A skip request from the execution stage turns the next instruction captured into a no-op. If that instruction is a two-byte one, its operand byte is still stepped over, so fetching resumes at the correct address.

A two-entry return-address stack sits beside the counter. The execution stage drives its push and pop strobes. A pop reloads the counter from the top of the stack. A jump loads any 12-bit address directly.

Top module: `lfsr_fetch_unit`

## Requirements
- R1: When `rst_n` is low at a clock edge, the unit resets. The counter becomes 0x000, the skip flag clears, both stack levels become 0x000, and `op_valid`, `opcode` and `operand` go to 0. The first fetch after reset reads address 0x000.
- R2: A sequential step shifts address bits [5:0] right by one place. The new bit 5 is 1 when bit 0 equals bit 1, and 0 otherwise.
- R3: A sequential step never changes address bits [11:6]. From any step value other than 0x3F, the steps return to the start value after 63 advances. Step 0x3F maps to itself.
- R4: Opcode 0x5F and opcodes 0x70 to 0x7F are two-byte instructions. The byte at the next step is delivered on `operand`, and the counter steps past it. A one-byte instruction reports `operand` = 0x00. In uninterrupted fetch, a one-byte instruction arrives 2 cycles after the previous `op_valid` and a two-byte instruction arrives 3 cycles after it.
- R5: When `jump_en` is high at an edge, the counter takes `jump_addr` in full. A jump overrides a sequential step and a pop; a pop that arrives with it leaves the stack unchanged. The instruction in flight at that edge is dropped and produces no `op_valid`.
- R6: `skip_req` sets a skip flag. The next instruction captured is delivered with `opcode` = 0x00 and `operand` = 0x00, and the flag clears. A skipped two-byte instruction still consumes its operand byte.
- R7: `push_en`, sampled in the cycle where `op_valid` is high, stores the address that follows the delivered instruction into level 0 and moves the old level 0 into level 1. The old level 1 is lost.
- R8: `pop_en` without `jump_en` reloads the counter from level 0, copies level 1 into level 0 and leaves level 1 unchanged. A pop drops the instruction in flight, as a jump does. A push that arrives in the same cycle as a pop is ignored.
- R9: `op_valid` is a one-cycle pulse per complete instruction. `opcode` and `operand` hold their values until the next pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| rom_addr | output | 12 | Program ROM address, equal to the counter |
| rom_en | output | 1 | ROM read strobe; data appears on `rom_data` one cycle later |
| rom_data | input | 8 | Byte read from the program ROM |
| skip_req | input | 1 | Turn the next captured instruction into a no-op |
| push_en | input | 1 | Push the next-instruction address onto the return stack |
| pop_en | input | 1 | Resume fetch at the top of the return stack |
| jump_en | input | 1 | Load `jump_addr` into the counter |
| jump_addr | input | 12 | Jump target: page in [11:6], step in [5:0] |
| op_valid | output | 1 | A complete instruction is on `opcode`/`operand` |
| opcode | output | 8 | First byte of the instruction (0x00 when skipped) |
| operand | output | 8 | Second byte of a two-byte instruction, else 0x00 |

## Verification
A wrong feedback bit or a page bit that leaks shows at once: the opcode stream diverges from the expected one on the next one-byte instruction. Each ROM byte encodes its own step, and a full 63-step walk shows any shortened or broken cycle within one page walk. A wrong length decode or a bad skip flag shows within one instruction, as a shifted stream, a wrong operand or a spacing of 2 cycles where 3 are expected. A corrupted stack level shows only when it is popped, and the ordered push/pop sequences pop every level, including the retained level 1 after the stack empties.

// File: rtl/lfsr_fetch_pkg.sv
// Package: shared phase encoding and opcode-length decode for the fetch unit.
// Assumes 8-bit opcodes. The two-byte opcode set is fixed by the instruction encoding.
package lfsr_fetch_pkg;

    localparam int OPC_W = 8;
    localparam logic [OPC_W-1:0] LONG_SINGLE = 8'h5F;
    localparam logic [3:0] LONG_NIBBLE = 4'h7;
    localparam logic [OPC_W-1:0] NOP_CODE = 8'h00;

    typedef enum logic [1:0] {
        PH_ADDR = 2'd0,   // issue opcode address
        PH_OP   = 2'd1,   // opcode on rom_data
        PH_ARG  = 2'd2    // operand on rom_data
    } fetch_phase_e;

    // Returns 1 when an opcode is followed by an operand byte.
    function automatic logic is_long_op(input logic [OPC_W-1:0] op);
        return (op == LONG_SINGLE) || (op[OPC_W-1:OPC_W-4] == LONG_NIBBLE);
    endfunction

endpackage

// File: rtl/lfsr_step_counter.sv
// Module: program counter made of a page field and an LFSR step field.
// A load takes the whole address and wins over an advance. An advance moves only
// the step field along the XNOR-feedback sequence and keeps the page.
// Assumes STEP_W >= 2.
module lfsr_step_counter #(
    parameter int PAGE_W = 6,
    parameter int STEP_W = 6
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     adv_en,
    input  logic                     load_en,
    input  logic [PAGE_W+STEP_W-1:0] load_addr,
    output logic [PAGE_W+STEP_W-1:0] pc
);
    localparam int PC_W = PAGE_W + STEP_W;

    logic [STEP_W-1:0] step_q;
    logic [STEP_W-1:0] step_adv;
    logic [PAGE_W-1:0] page_q;

    // Next step value: shift right and feed the XNOR of the two low bits into the top.
    always_comb begin
        step_adv = {step_q[0] ~^ step_q[1], step_q[STEP_W-1:1]};
    end

    // Counter register: reset, load, or advance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            page_q <= '0;
            step_q <= '0;
        end else if (load_en) begin
            page_q <= load_addr[PC_W-1:STEP_W];
            step_q <= load_addr[STEP_W-1:0];
        end else if (adv_en) begin
            step_q <= step_adv;
        end
    end

    assign pc = {page_q, step_q};

endmodule

// File: rtl/ret_addr_stack.sv
// Module: return-address stack with a fixed number of levels. It shifts on push and pop.
// A push inserts at level 0 and the deepest entry falls off. A pop shifts toward level 0
// and the deepest level keeps its value. Assumes DEPTH >= 2 and no push and pop together.
module ret_addr_stack #(
    parameter int ADDR_W = 12,
    parameter int DEPTH  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic              pop,
    input  logic [ADDR_W-1:0] push_addr,
    output logic [ADDR_W-1:0] top_addr
);
    logic [DEPTH-1:0][ADDR_W-1:0] lvl_q;

    // Stack storage: clear on reset, shift on pop or push.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lvl_q <= '0;
        end else if (pop) begin
            lvl_q <= {lvl_q[DEPTH-1], lvl_q[DEPTH-1:1]};
        end else if (push) begin
            lvl_q <= {lvl_q[DEPTH-2:0], push_addr};
        end
    end

    assign top_addr = lvl_q[0];

endmodule

// File: rtl/fetch_sequencer.sv
// Module: byte-fetch phase machine. It issues ROM reads, detects two-byte opcodes,
// applies a pending skip and presents complete instructions.
// Assumes a ROM that returns data one cycle after rom_en. A redirect (jump or pop)
// drops the instruction in flight and restarts at the address phase.
module fetch_sequencer
    import lfsr_fetch_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             redirect,
    input  logic             skip_req,
    input  logic [OPC_W-1:0] rom_data,
    output logic             rd_en,
    output logic             op_valid,
    output logic [OPC_W-1:0] opcode,
    output logic [OPC_W-1:0] operand
);
    fetch_phase_e     phase_q;
    logic             skip_q;
    logic             skipped_q;
    logic [OPC_W-1:0] op_hold_q;
    logic             data_long;
    logic             consume;

    // Length decode of the byte now on the ROM data port.
    always_comb begin
        data_long = is_long_op(rom_data);
        consume   = (phase_q == PH_OP) && !redirect;
        rd_en     = !redirect && ((phase_q == PH_ADDR) || ((phase_q == PH_OP) && data_long));
    end

    // Skip flag: set by request, cleared when an opcode is captured.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            skip_q <= 1'b0;
        end else begin
            skip_q <= skip_req || (skip_q && !consume);
        end
    end

    // Phase machine and instruction output registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q   <= PH_ADDR;
            op_valid  <= 1'b0;
            opcode    <= '0;
            operand   <= '0;
            op_hold_q <= '0;
            skipped_q <= 1'b0;
        end else begin
            op_valid <= 1'b0;
            if (redirect) begin
                phase_q <= PH_ADDR;
            end else begin
                unique case (phase_q)
                    PH_ADDR: phase_q <= PH_OP;
                    PH_OP: begin
                        if (data_long) begin
                            op_hold_q <= skip_q ? NOP_CODE : rom_data;
                            skipped_q <= skip_q;
                            phase_q   <= PH_ARG;
                        end else begin
                            opcode   <= skip_q ? NOP_CODE : rom_data;
                            operand  <= NOP_CODE;
                            op_valid <= 1'b1;
                            phase_q  <= PH_ADDR;
                        end
                    end
                    PH_ARG: begin
                        opcode   <= op_hold_q;
                        operand  <= skipped_q ? NOP_CODE : rom_data;
                        op_valid <= 1'b1;
                        phase_q  <= PH_ADDR;
                    end
                    default: phase_q <= PH_ADDR;
                endcase
            end
        end
    end

endmodule

// File: rtl/lfsr_fetch_unit.sv
// Module: top of the fetch unit. Joins the LFSR program counter, the byte-fetch
// sequencer and the return-address stack.
// Assumes the execution stage raises push_en only in a cycle where op_valid is high.
// Priority for the next counter value: jump, then pop, then sequential advance.
module lfsr_fetch_unit #(
    parameter int PAGE_W      = 6,
    parameter int STEP_W      = 6,
    parameter int STACK_DEPTH = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    output logic [PAGE_W+STEP_W-1:0] rom_addr,
    output logic                     rom_en,
    input  logic [7:0]               rom_data,
    input  logic                     skip_req,
    input  logic                     push_en,
    input  logic                     pop_en,
    input  logic                     jump_en,
    input  logic [PAGE_W+STEP_W-1:0] jump_addr,
    output logic                     op_valid,
    output logic [7:0]               opcode,
    output logic [7:0]               operand
);
    localparam int PC_W = PAGE_W + STEP_W;

    logic [PC_W-1:0] pc;
    logic [PC_W-1:0] stk_top;
    logic [PC_W-1:0] load_addr;
    logic            redirect;
    logic            stk_pop;
    logic            stk_push;

    // Redirect selection: a jump overrides a pop; a pop overrides a push.
    always_comb begin
        redirect  = jump_en || pop_en;
        load_addr = jump_en ? jump_addr : stk_top;
        stk_pop   = pop_en && !jump_en;
        stk_push  = push_en && !pop_en;
    end

    lfsr_step_counter #(
        .PAGE_W (PAGE_W),
        .STEP_W (STEP_W)
    ) u_pc (
        .clk       (clk),
        .rst_n     (rst_n),
        .adv_en    (rom_en),
        .load_en   (redirect),
        .load_addr (load_addr),
        .pc        (pc)
    );

    fetch_sequencer u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .redirect (redirect),
        .skip_req (skip_req),
        .rom_data (rom_data),
        .rd_en    (rom_en),
        .op_valid (op_valid),
        .opcode   (opcode),
        .operand  (operand)
    );

    ret_addr_stack #(
        .ADDR_W (PC_W),
        .DEPTH  (STACK_DEPTH)
    ) u_stk (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (stk_push),
        .pop       (stk_pop),
        .push_addr (pc),
        .top_addr  (stk_top)
    );

    assign rom_addr = pc;

endmodule

// File: rtl/lfsr_fetch_unit_chk.sv
// Module: assertion checker for the fetch unit, attached to the top by bind.
// Relates the ROM port, the redirect inputs, the stack top and the output pulses over time.
module lfsr_fetch_unit_chk
    import lfsr_fetch_pkg::*;
#(
    parameter int PAGE_W = 6,
    parameter int STEP_W = 6
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic [PAGE_W+STEP_W-1:0] rom_addr,
    input logic                     rom_en,
    input logic                     jump_en,
    input logic                     pop_en,
    input logic [PAGE_W+STEP_W-1:0] jump_addr,
    input logic [PAGE_W+STEP_W-1:0] stk_top,
    input logic                     op_valid,
    input logic [7:0]               opcode
);
    localparam int PC_W = PAGE_W + STEP_W;

    AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (!op_valid && rom_addr == '0)); // R1

    AST_STEP_RULE: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(rom_en) && !$past(jump_en) && !$past(pop_en))
        |-> (rom_addr[STEP_W-1:0] ==
             {$past(rom_addr[0] ~^ rom_addr[1]), $past(rom_addr[STEP_W-1:1])})); // R2

    AST_PAGE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(jump_en) && !$past(pop_en))
        |-> (rom_addr[PC_W-1:STEP_W] == $past(rom_addr[PC_W-1:STEP_W]))); // R3

    AST_LONG_OPERAND_READ: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n, 2) && op_valid && is_long_op(opcode)) |-> $past(rom_en, 2)); // R4

    AST_JUMP_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(jump_en)) |-> (rom_addr == $past(jump_addr) && !op_valid)); // R5

    AST_POP_RESUME: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(pop_en) && !$past(jump_en))
        |-> (rom_addr == $past(stk_top) && !op_valid)); // R8

    AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid |=> !op_valid); // R9

endmodule

bind lfsr_fetch_unit lfsr_fetch_unit_chk #(
    .PAGE_W (PAGE_W),
    .STEP_W (STEP_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .rom_addr  (rom_addr),
    .rom_en    (rom_en),
    .jump_en   (jump_en),
    .pop_en    (pop_en),
    .jump_addr (jump_addr),
    .stk_top   (stk_top),
    .op_valid  (op_valid),
    .opcode    (opcode)
);

// File: tb/lfsr_fetch_unit_test.sv
`timescale 1ns/1ps
// Scoreboard bench: driver tasks predict instruction streams into a queue and a
// negedge monitor compares each op_valid pulse against the head of the queue.
module lfsr_fetch_unit_test;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [11:0] rom_addr;
    logic        rom_en;
    logic [7:0]  rom_data = 8'h00;
    logic        skip_req, push_en, pop_en, jump_en;
    logic [11:0] jump_addr;
    logic        op_valid;
    logic [7:0]  opcode, operand;

    always #2 clk = ~clk;   // 250 MHz

    lfsr_fetch_unit uut (
        .clk(clk), .rst_n(rst_n), .rom_addr(rom_addr), .rom_en(rom_en),
        .rom_data(rom_data), .skip_req(skip_req), .push_en(push_en),
        .pop_en(pop_en), .jump_en(jump_en), .jump_addr(jump_addr),
        .op_valid(op_valid), .opcode(opcode), .operand(operand)
    );

    logic [7:0] rom_mem [0:4095];
    always @(posedge clk) if (rom_en) rom_data <= rom_mem[rom_addr];

    typedef struct {
        logic [7:0] op;
        logic [7:0] arg;
        int         gap;
        string      tag;
    } item_t;

    item_t       exp_q[$];
    int          n_tests = 0;
    int          n_fail  = 0;
    int          cyc     = 0;
    int          last_cyc = 0;
    logic [11:0] stk0 = 12'h000;
    logic [11:0] stk1 = 12'h000;

    function automatic logic [11:0] adv12(input logic [11:0] a);
        return {a[11:6], a[0] ~^ a[1], a[5:1]};
    endfunction

    function automatic bit long_op(input logic [7:0] o);
        return (o == 8'h5F) || (o[7:4] == 4'h7);
    endfunction

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int expv);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, expv);
        end
    endtask

    // Monitor: compare each delivered instruction with the predicted one.
    always @(negedge clk) begin
        item_t e;
        cyc++;
        if (rst_n && op_valid && exp_q.size() > 0) begin
            e = exp_q.pop_front();
            check(opcode == e.op, e.tag, "opcode", opcode, e.op);
            check(operand == e.arg, e.tag, "operand", operand, e.arg);
            if (e.gap != 0) check(cyc - last_cyc == e.gap, "R4", "valid spacing", cyc - last_cyc, e.gap);
        end
        if (op_valid) last_cyc = cyc;
    end

    // Driver helper: predict n instructions starting at address a.
    task automatic expect_from(input logic [11:0] a, input int n, input bit skip, input string tag);
        logic [11:0] pc = a;
        for (int i = 0; i < n; i++) begin
            item_t it;
            bit    lg;
            it.op  = rom_mem[pc];
            it.arg = 8'h00;
            lg     = long_op(it.op);
            pc     = adv12(pc);
            if (lg) begin
                it.arg = rom_mem[pc];
                pc     = adv12(pc);
            end
            if (skip && i == 0) begin
                it.op  = 8'h00;
                it.arg = 8'h00;
            end
            it.gap = (i == 0) ? 0 : (lg ? 3 : 2);
            it.tag = tag;
            exp_q.push_back(it);
        end
    endtask

    task automatic wait_drain();
        while (exp_q.size() != 0) @(negedge clk);
    endtask

    // mode 0: jump, 1: pop, 2: jump and pop together (jump wins, stack kept).
    task automatic redirect(input int mode, input logic [11:0] a, input bit skip,
                            input int n, input string tag);
        logic [11:0] start;
        wait_drain();
        @(negedge clk);
        jump_en   = (mode != 1);
        pop_en    = (mode != 0);
        jump_addr = a;
        skip_req  = skip;
        start     = (mode == 1) ? stk0 : a;
        if (mode == 1) stk0 = stk1;
        @(negedge clk);
        jump_en  = 1'b0;
        pop_en   = 1'b0;
        skip_req = 1'b0;
        expect_from(start, n, skip, tag);
    endtask

    // Push while the next instruction is being delivered; ret is the address after it.
    task automatic push_on_valid(input logic [11:0] ret);
        @(negedge clk);
        while (!op_valid) @(negedge clk);
        push_en = 1'b1;
        stk1 = stk0;
        stk0 = ret;
        @(negedge clk);
        push_en = 1'b0;
    endtask

    initial begin
        logic [11:0] p;
        rst_n = 1'b0; skip_req = 1'b0; push_en = 1'b0; pop_en = 1'b0;
        jump_en = 1'b0; jump_addr = 12'h000;
        for (int i = 0; i < 4096; i++) rom_mem[i] = 8'h80 | 8'(i & 8'h7F);

        // Page 9 program with both two-byte forms and one-byte neighbours 0x5E, 0x6F.
        p = {6'd9, 6'h01};
        rom_mem[p] = 8'h5F; p = adv12(p);
        rom_mem[p] = 8'hA5; p = adv12(p);
        rom_mem[p] = 8'h73; p = adv12(p);
        rom_mem[p] = 8'h3C; p = adv12(p);
        rom_mem[p] = 8'h6F; p = adv12(p);
        rom_mem[p] = 8'h7F; p = adv12(p);
        rom_mem[p] = 8'h11; p = adv12(p);
        rom_mem[p] = 8'h5E;

        // R1: reset state at the ports
        repeat (3) @(negedge clk);
        check(op_valid == 1'b0, "R1", "op_valid in reset", op_valid, 0);
        check(rom_addr == 12'h000, "R1", "rom_addr in reset", rom_addr, 0);
        check(opcode == 8'h00, "R1", "opcode in reset", opcode, 0);
        rst_n = 1'b1;
        expect_from(12'h000, 4, 1'b0, "R1");

        // R8 with R1: pop on an empty stack resumes at 0x000
        redirect(1, 12'h000, 1'b0, 3, "R8");

        // R2: full LFSR walk, 64 instructions wrap back to the start
        redirect(0, {6'h17, 6'h05}, 1'b0, 64, "R2");
        redirect(0, {6'h2A, 6'h3E}, 1'b0, 64, "R3");
        // R3: lock-up step repeats, top page stays in page
        redirect(0, {6'h02, 6'h3F}, 1'b0, 5, "R3");
        redirect(0, 12'hFFE, 1'b0, 10, "R3");

        // R4: two-byte decode and operand fetch
        redirect(0, {6'd9, 6'h01}, 1'b0, 7, "R4");

        // R6: skip on one-byte and on two-byte instructions
        redirect(0, {6'h03, 6'h10}, 1'b1, 3, "R6");
        redirect(0, {6'd9, 6'h01}, 1'b1, 4, "R6");

        // R7 / R8: two pushes then three pops (level 1 retained)
        redirect(0, {6'h04, 6'h01}, 1'b0, 2, "R7");
        push_on_valid(adv12({6'h04, 6'h01}));
        redirect(0, {6'h06, 6'h07}, 1'b0, 2, "R7");
        push_on_valid(adv12({6'h06, 6'h07}));
        redirect(1, 12'h000, 1'b0, 2, "R8");
        redirect(1, 12'h000, 1'b0, 2, "R8");
        redirect(1, 12'h000, 1'b0, 2, "R8");

        // R7: three pushes, the oldest is dropped
        redirect(0, {6'h21, 6'h02}, 1'b0, 2, "R7");
        push_on_valid(adv12({6'h21, 6'h02}));
        redirect(0, {6'h22, 6'h03}, 1'b0, 2, "R7");
        push_on_valid(adv12({6'h22, 6'h03}));
        redirect(0, {6'h23, 6'h04}, 1'b0, 2, "R7");
        push_on_valid(adv12({6'h23, 6'h04}));

        // R5: jump together with pop goes to the jump target, stack untouched
        redirect(2, {6'h30, 6'h09}, 1'b0, 3, "R5");
        redirect(1, 12'h000, 1'b0, 2, "R7");
        redirect(1, 12'h000, 1'b0, 2, "R7");
        redirect(1, 12'h000, 1'b0, 2, "R8");

        wait_drain();
        repeat (4) @(negedge clk);
        check(exp_q.size() == 0, "R9", "items left", exp_q.size(), 0);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (100000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual=%0d pending expected=0", exp_q.size());
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule